// File: doc/BRIEF.md
# Serial Port Bit-Clock Generator

This block produces the bit clock for a serial port's transmit and receive sections. It runs entirely in the system clock domain. The reference that paces it is either the system clock itself or an external clock. The external clock is brought in through a synchronizer, and only its rising edges count. Each counted reference period is a "tick". An 8-bit divide value sets how many ticks the output spends high and low. A zero divide value gives the fastest clock the reference allows.

Besides the clock itself, the block emits two strobes, each one system clock wide. One marks each rising edge of the generated clock and the other marks each falling edge, so that shifters and frame logic can act on them without an edge detector of their own. A polarity bit inverts the clock at the output pin. A run enable holds the generator idle and restarts it cleanly. A new divide value is adopted only where a high phase begins, so a change never produces a runt pulse.

Top module: `bitclk_gen`

## Requirements
- R1: With `src_sys_i` = 1 every system clock is a tick. With `src_sys_i` = 0 a tick is each rising edge of `ext_clk_i`, seen after a two-flop synchronizer.
- R2: For an even nonzero divide value d, the high phase lasts d/2 + 1 ticks and the low phase lasts d/2 ticks.
- R3: For an odd divide value d, both the high and the low phase last (d + 1)/2 ticks.
- R4: A divide value of zero gives a high phase of one tick and a low phase of one tick. With the system clock as reference this is the minimum period of two system clocks.
- R5: With `inv_i` = 1, `bclk_o` is the complement of the uninverted clock. The strobes keep following the uninverted clock.
- R6: While `run_i` = 0 the uninverted clock is low, so `bclk_o` equals `inv_i`, and no strobe is issued. The first transition after `run_i` rises is a rising edge, taken on the first tick.
- R7: A divide value is sampled at the tick that starts a high phase. The high phase and the low phase that follows both use that sampled value, whatever `div_i` does later.
- R8: `rise_o` and `fall_o` each pulse for exactly one system clock. A pulse appears in the cycle in which the uninverted clock has just risen or fallen, and the two never pulse together.
- R9: During reset `bclk_o` equals `inv_i` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_i | input | 1 | External reference clock, asynchronous, slower than half the system clock |
| src_sys_i | input | 1 | Reference select: 1 system clock, 0 external clock |
| div_i | input | 8 | Divide value |
| inv_i | input | 1 | Output polarity invert |
| run_i | input | 1 | Run enable |
| bclk_o | output | 1 | Generated bit clock, after polarity control |
| rise_o | output | 1 | One-cycle strobe on each rising edge of the uninverted clock |
| fall_o | output | 1 | One-cycle strobe on each falling edge of the uninverted clock |

## Verification
A divide-value change and the start of a high phase can land on the same tick, and that tick must pick up the new value at once. The bench waits for a falling strobe and writes a new divide value in that same cycle. The following low phase is one tick long, so the very next tick opens a high phase with the new value on `div_i`. The low phase just ended must still have the old length, and the high and low phases that follow must have the lengths of the new value. Those phase lengths are measured in system clocks between strobes.

// File: rtl/bitclk_pkg.sv
// Package: bitclk_pkg
// Shared types for the bit-clock generator. Holds the phase state
// encoding used by the phase counter.
package bitclk_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_t;

endpackage

// File: rtl/bitclk_sync.sv
// Module: bitclk_sync
// Brings an asynchronous reference clock into the system domain through
// SYNC_STAGES flops and emits a one-cycle pulse for each rising edge.
// Assumes the external clock's high and low times each exceed one
// system clock period, so that no edge is lost.
module bitclk_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_pulse_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Synchronizer chain plus one flop that holds the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], async_i};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Rising edge: synchronized level high, previous level low.
    always_comb begin
        rise_pulse_o = sync_q[SYNC_STAGES-1] & ~last_q;
    end

    // R1: the edge pulse is never longer than one cycle.
    p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse_o |=> !rise_pulse_o);

endmodule

// File: rtl/bitclk_phase.sv
// Module: bitclk_phase
// Counts ticks through alternating high and low phases. It samples the
// divide value when a high phase starts and issues one-cycle strobes
// at each transition. Assumes tick_i is a single-cycle qualifier in
// the system clock domain. run_i low forces the idle state.
module bitclk_phase
    import bitclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             lvl_o,
    output logic             rise_o,
    output logic             fall_o
);

    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    phase_t           state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] cur_div_q, cur_div_d;
    logic             rise_q, rise_d;
    logic             fall_q, fall_d;

    // Ticks remaining after the first tick of a high phase.
    function automatic logic [DIV_W-1:0] high_rem(input logic [DIV_W-1:0] d);
        return (d == '0) ? '0 : (d >> 1);
    endfunction

    // Ticks remaining after the first tick of a low phase.
    function automatic logic [DIV_W-1:0] low_rem(input logic [DIV_W-1:0] d);
        if (d == '0)  return '0;
        else if (d[0]) return d >> 1;
        else          return (d >> 1) - ONE;
    endfunction

    // Next-state logic: advance the phase on a tick, counting down.
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        cur_div_d = cur_div_q;
        rise_d    = 1'b0;
        fall_d    = 1'b0;
        if (tick_i) begin
            unique case (state_q)
                PH_IDLE, PH_LOW: begin
                    if (state_q == PH_IDLE || cnt_q == '0) begin
                        state_d   = PH_HIGH;
                        cur_div_d = div_i;
                        cnt_d     = high_rem(div_i);
                        rise_d    = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                PH_HIGH: begin
                    if (cnt_q == '0) begin
                        state_d = PH_LOW;
                        cnt_d   = low_rem(cur_div_q);
                        fall_d  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                default: state_d = PH_IDLE;
            endcase
        end
    end

    // State register; reset and a low run enable both force idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            state_q   <= PH_IDLE;
            cnt_q     <= '0;
            cur_div_q <= '0;
            rise_q    <= 1'b0;
            fall_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            cur_div_q <= cur_div_d;
            rise_q    <= rise_d;
            fall_q    <= fall_d;
        end
    end

    // Drive outputs from registered state.
    always_comb begin
        lvl_o  = (state_q == PH_HIGH);
        rise_o = rise_q;
        fall_o = fall_q;
    end

    // R8: strobes are single-cycle and mutually exclusive.
    p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    p_fall_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o));
    // R6: a low run enable leaves the clock low with no strobe.
    p_run_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!lvl_o && !rise_o && !fall_o));
    // R1: the level only moves on a tick.
    p_move_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(lvl_o));

endmodule

// File: rtl/bitclk_gen.sv
// Module: bitclk_gen
// Top of the serial bit-clock generator. It selects the tick source
// (system clock or synchronized external clock), runs the phase
// counter and applies output polarity. Assumes all control inputs are
// synchronous to clk and that the external clock is asynchronous.
module bitclk_gen #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic             src_sys_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             inv_i,
    input  logic             run_i,
    output logic             bclk_o,
    output logic             rise_o,
    output logic             fall_o
);

    logic ext_rise;
    logic tick;
    logic lvl;

    bitclk_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .async_i      (ext_clk_i),
        .rise_pulse_o (ext_rise)
    );

    // Tick source: every cycle, or each synchronized external rising edge.
    always_comb begin
        tick = src_sys_i ? 1'b1 : ext_rise;
    end

    bitclk_phase #(
        .DIV_W (DIV_W)
    ) i_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_i),
        .tick_i (tick),
        .div_i  (div_i),
        .lvl_o  (lvl),
        .rise_o (rise_o),
        .fall_o (fall_o)
    );

    // Polarity control at the pin.
    always_comb begin
        bclk_o = lvl ^ inv_i;
    end

    // R5: a strobe marks the edge of the uninverted level at the pin.
    p_rise_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> (bclk_o == ~inv_i));

endmodule

// File: tb/test_bitclk_gen.sv
module test_bitclk_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic       src_sys = 1'b1;
    logic [7:0] div = 8'd0;
    logic       inv = 1'b0;
    logic       run = 1'b0;
    logic       bclk, rise, fall;

    int errors = 0;
    int checks = 0;
    int ext_div = 0;

    bitclk_gen i_bitclk_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_clk_i (ext_clk),
        .src_sys_i (src_sys),
        .div_i     (div),
        .inv_i     (inv),
        .run_i     (run),
        .bclk_o    (bclk),
        .rise_o    (rise),
        .fall_o    (fall)
    );

    always #2 clk = ~clk;

    // External clock: toggles every 3 system clocks, period 6.
    always @(negedge clk) begin
        if (ext_div == 2) begin
            ext_div = 0;
            ext_clk = ~ext_clk;
        end else begin
            ext_div = ext_div + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_rise(input string req);
        int n = 0;
        while (!rise && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!rise) chk(req, "rise strobe timeout", 0, 1);
    endtask

    // Starting at a cycle with rise seen, count high then low cycles.
    task automatic count_phase(input string req, output int hi, output int lo);
        hi = 0;
        lo = 0;
        do begin
            @(negedge clk);
            hi++;
            if (rise && !fall) chk("R8", "rise repeated in high phase", 1, 0);
        end while (!fall && hi < 2000);
        do begin
            @(negedge clk);
            lo++;
            if (fall && !rise) chk("R8", "fall repeated in low phase", 1, 0);
        end while (!rise && lo < 2000);
    endtask

    task automatic restart(input logic s, input logic [7:0] d, input logic iv);
        @(negedge clk);
        run = 1'b0;
        src_sys = s;
        div = d;
        inv = iv;
        repeat (2) @(negedge clk);
        run = 1'b1;
    endtask

    task automatic measure(input string req, input logic s, input logic [7:0] d,
                           input int exp_hi, input int exp_lo);
        int hi, lo;
        restart(s, d, 1'b0);
        wait_rise(req);
        count_phase(req, hi, lo);
        chk(req, $sformatf("high cycles div=%0d", d), hi, exp_hi);
        chk(req, $sformatf("low cycles div=%0d", d), lo, exp_lo);
    endtask

    task automatic test_reset();
        // R9: reset state.
        chk("R9", "bclk in reset", int'(bclk), 0);
        chk("R9", "rise in reset", int'(rise), 0);
        chk("R9", "fall in reset", int'(fall), 0);
    endtask

    task automatic test_even();
        measure("R2", 1'b1, 8'd4, 3, 2);
        measure("R2", 1'b1, 8'd2, 2, 1);
        measure("R2", 1'b1, 8'd10, 6, 5);
    endtask

    task automatic test_odd();
        measure("R3", 1'b1, 8'd5, 3, 3);
        measure("R3", 1'b1, 8'd1, 1, 1);
        measure("R3", 1'b1, 8'd255, 128, 128);
    endtask

    task automatic test_zero();
        measure("R4", 1'b1, 8'd0, 1, 1);
    endtask

    task automatic test_source();
        // R1: each external tick is 6 system clocks.
        measure("R1", 1'b0, 8'd3, 12, 12);
        measure("R1", 1'b0, 8'd2, 12, 6);
        measure("R1", 1'b1, 8'd3, 2, 2);
    endtask

    task automatic test_invert();
        restart(1'b1, 8'd3, 1'b1);
        chk("R5", "inverted idle level", int'(bclk), 1);
        wait_rise("R5");
        chk("R5", "pin low at rise strobe", int'(bclk), 0);
        while (!fall) @(negedge clk);
        chk("R5", "pin high at fall strobe", int'(bclk), 1);
    endtask

    task automatic test_run_gate();
        int strobes = 0;
        @(negedge clk);
        run = 1'b0;
        inv = 1'b0;
        src_sys = 1'b1;
        div = 8'd6;
        repeat (5) begin
            @(negedge clk);
            strobes += int'(rise) + int'(fall);
        end
        chk("R6", "idle level", int'(bclk), 0);
        chk("R6", "strobes while stopped", strobes, 0);
        run = 1'b1;
        @(negedge clk);
        chk("R6", "first strobe is rise", int'(rise), 1);
        chk("R6", "no fall on start", int'(fall), 0);
        chk("R6", "clock high after start", int'(bclk), 1);
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        chk("R6", "level after stop", int'(bclk), 0);
        chk("R6", "no fall strobe on stop", int'(fall), 0);
    endtask

    task automatic test_div_change();
        int hi, lo;
        restart(1'b1, 8'd4, 1'b0);
        wait_rise("R7");
        div = 8'd7;
        count_phase("R7", hi, lo);
        chk("R7", "old high kept", hi, 3);
        chk("R7", "old low kept", lo, 2);
        count_phase("R7", hi, lo);
        chk("R7", "new high", hi, 4);
        chk("R7", "new low", lo, 4);
    endtask

    task automatic test_boundary();
        int lo = 0;
        int hi2, lo2;
        restart(1'b1, 8'd2, 1'b0);
        wait_rise("R7");
        while (!fall) @(negedge clk);
        div = 8'd5;
        do begin
            @(negedge clk);
            lo++;
        end while (!rise && lo < 100);
        chk("R7", "boundary low uses old value", lo, 1);
        count_phase("R7", hi2, lo2);
        chk("R7", "boundary high uses new value", hi2, 3);
        chk("R7", "boundary low after new value", lo2, 3);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_even();
        test_odd();
        test_zero();
        test_source();
        test_invert();
        test_run_gate();
        test_div_change();
        test_boundary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule